// File: doc/BRIEF.md
# Bytecode Instruction Length Decoder

This block takes a program for a register-based bytecode machine one byte at a time and splits it into instructions. Instructions are packed with no alignment: an opcode byte is followed directly by its parameter bytes. The opcode alone selects one of six parameter formats, and the format fixes the instruction length. For each complete instruction the block emits one record. The record holds the opcode, the format code, the total length, the register operand bytes, the 64-bit immediate and the byte offset of the opcode within the program.

Three faults make a program invalid: an opcode outside the defined set, a register operand of 60 or more, and a program that ends partway through an instruction. Each fault produces a single error record, and the block then drops input until the next start-of-program marker. Every byte may carry a start-of-program flag, and the last byte of a program carries an end-of-program flag. The input is always ready. Both kinds of record appear one clock after the byte that completes or breaks an instruction.

Top module: `hbd_decoder`

## Requirements
- R1: The opcode selects the format and the total length (format codes in brackets). Opcodes 0 and 45 are N [0], 1 byte. Opcodes 13, 14 and 28 are RR [1], 3 bytes. Opcodes 1–11 and 46–47 are RRR [2], 4 bytes. Opcodes 12 and 48 are RRRR [3], 5 bytes. Opcodes 29 and 38 are RI [4], 10 bytes. Opcodes 18–27, 30–37, 39–44 and 49–50 are RRI [5], 11 bytes.
- R2: `rec_valid` pulses for one cycle, one clock after the last byte of an instruction is accepted. `rec_offset` holds the program offset of that instruction's opcode byte, and the start-of-program byte has offset 0.
- R3: Register operands are the first parameter bytes, as many as the format names (R letters). Operand k appears in `rec_regs[8k+7:8k]`, and unused slots read zero.
- R4: The immediate follows the register bytes, least significant byte first, and appears in `rec_imm`. It reads zero for formats without an immediate.
- R5: An undefined opcode (15–17 or 51–255) gives `err_valid` with code 1, `err_pos` 0, `err_value` equal to the opcode and `err_offset` equal to its offset.
- R6: A register byte of 60 or more gives error code 2. `err_pos` is the byte's index within the instruction (opcode = 0), `err_value` is the byte, and `err_offset` is the instruction start. The value 59 is accepted.
- R7: An end-of-program flag on a byte that does not complete the instruction gives error code 3. `err_offset` is the instruction start, `err_pos` is the index of the first missing byte, and `err_value` is 0.
- R8: After any error, bytes without a start-of-program flag are ignored and produce no record.
- R9: A start-of-program flag always begins a new program at offset 0 and discards any partial instruction in progress.
- R10: An end-of-program flag on a byte that completes an instruction yields a normal record, and later bytes without a start flag are ignored.
- R11: `rec_valid` and `err_valid` are never high together. When the byte that carries the end flag is also an out-of-range register, code 2 is reported, not code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Byte accepted (always 1) |
| in_data | input | 8 | Program byte |
| in_sop | input | 1 | Byte is the first of a program |
| in_eop | input | 1 | Byte is the last of a program |
| rec_valid | output | 1 | Decoded instruction record valid |
| rec_opcode | output | 8 | Opcode byte |
| rec_fmt | output | 3 | Format code (R1) |
| rec_len | output | 4 | Total instruction length in bytes |
| rec_regs | output | 32 | Register operand bytes |
| rec_imm | output | 64 | Immediate value |
| rec_offset | output | OFF_W | Offset of the opcode byte |
| err_valid | output | 1 | Error record valid |
| err_code | output | 2 | 1 opcode, 2 register, 3 truncated |
| err_offset | output | OFF_W | Offset of the faulting instruction |
| err_pos | output | 4 | Index of the faulting byte in the instruction |
| err_value | output | 8 | Offending byte, 0 for truncation |

## Verification
On a single byte, the end-of-program flag can coincide with instruction completion, with an out-of-range register, or with an opcode byte that has parameters still to come. The bench drives each of these cases as the last byte of a short program. It judges them by which record appears one clock later: a normal record when the byte completes the instruction, code 2 (and not code 3) for a bad register, and code 3 with position 1 for an opcode cut short. A start flag arriving in the middle of an instruction is also provoked, to show that the restart takes precedence over the partial instruction.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int MAX_REGS  = 4;
    localparam int IMM_BYTES = 8;
    localparam int POS_W     = 4;
    localparam int LANES     = MAX_REGS + IMM_BYTES;

    typedef enum logic [2:0] {
        FMT_N    = 3'd0,
        FMT_RR   = 3'd1,
        FMT_RRR  = 3'd2,
        FMT_RRRR = 3'd3,
        FMT_RI   = 3'd4,
        FMT_RRI  = 3'd5
    } fmt_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_OPCODE = 2'd1,
        ERR_REG    = 2'd2,
        ERR_TRUNC  = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPC   = 2'd1,
        ST_PARAM = 2'd2
    } st_e;

    function automatic logic [POS_W-1:0] fmt_nregs(fmt_e f);
        case (f)
            FMT_RR:   return POS_W'(2);
            FMT_RRR:  return POS_W'(3);
            FMT_RRRR: return POS_W'(4);
            FMT_RI:   return POS_W'(1);
            FMT_RRI:  return POS_W'(2);
            default:  return '0;
        endcase
    endfunction

    function automatic logic fmt_has_imm(fmt_e f);
        return (f == FMT_RI) || (f == FMT_RRI);
    endfunction

    function automatic logic [POS_W-1:0] fmt_len(fmt_e f);
        return POS_W'(1) + fmt_nregs(f) + (fmt_has_imm(f) ? POS_W'(IMM_BYTES) : '0);
    endfunction

endpackage

// File: rtl/hbd_opclass.sv
module hbd_opclass
    import hbd_pkg::*;
(
    input  logic [7:0] opcode,
    output fmt_e       fmt,
    output logic       known
);

    always_comb begin
        known = 1'b1;
        fmt   = FMT_N;
        if (opcode inside {8'd0, 8'd45}) begin
            fmt = FMT_N;
        end else if (opcode inside {[8'd1:8'd11], [8'd46:8'd47]}) begin
            fmt = FMT_RRR;
        end else if (opcode inside {8'd12, 8'd48}) begin
            fmt = FMT_RRRR;
        end else if (opcode inside {8'd13, 8'd14, 8'd28}) begin
            fmt = FMT_RR;
        end else if (opcode inside {8'd29, 8'd38}) begin
            fmt = FMT_RI;
        end else if (opcode inside {[8'd18:8'd27], [8'd30:8'd37],
                                    [8'd39:8'd44], [8'd49:8'd50]}) begin
            fmt = FMT_RRI;
        end else begin
            known = 1'b0;
        end
    end

endmodule

// File: rtl/hbd_fieldmap.sv
module hbd_fieldmap
    import hbd_pkg::*;
(
    input  logic                 en,
    input  fmt_e                 fmt,
    input  logic [POS_W-1:0]     pos,
    output logic [MAX_REGS-1:0]  reg_we,
    output logic [IMM_BYTES-1:0] imm_we,
    output logic                 last
);

    logic [POS_W-1:0] nregs;
    logic [POS_W-1:0] imm_rel;
    logic             in_regs;
    logic             in_imm;

    assign nregs   = fmt_nregs(fmt);
    assign in_regs = (pos != '0) && (pos <= nregs);
    assign in_imm  = fmt_has_imm(fmt) && (pos > nregs);
    assign imm_rel = pos - nregs - POS_W'(1);
    assign last    = (pos == fmt_len(fmt) - POS_W'(1));

    for (genvar k = 0; k < MAX_REGS; k++) begin : g_reg_lane
        assign reg_we[k] = en && in_regs && (pos == POS_W'(k + 1));
    end

    for (genvar k = 0; k < IMM_BYTES; k++) begin : g_imm_lane
        assign imm_we[k] = en && in_imm && (imm_rel == POS_W'(k));
    end

endmodule

// File: rtl/hbd_decoder.sv
module hbd_decoder
    import hbd_pkg::*;
#(
    parameter int REG_LIMIT = 60,
    parameter int OFF_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [7:0]                in_data,
    input  logic                      in_sop,
    input  logic                      in_eop,
    output logic                      rec_valid,
    output logic [7:0]                rec_opcode,
    output logic [2:0]                rec_fmt,
    output logic [POS_W-1:0]          rec_len,
    output logic [MAX_REGS*8-1:0]     rec_regs,
    output logic [IMM_BYTES*8-1:0]    rec_imm,
    output logic [OFF_W-1:0]          rec_offset,
    output logic                      err_valid,
    output logic [1:0]                err_code,
    output logic [OFF_W-1:0]          err_offset,
    output logic [POS_W-1:0]          err_pos,
    output logic [7:0]                err_value
);

    localparam logic [7:0] REG_LIM_B = 8'(REG_LIMIT);
    localparam int         REGS_W    = MAX_REGS * 8;
    localparam int         IMM_W     = IMM_BYTES * 8;

    typedef struct packed {
        st_e               st;
        logic [7:0]        op;
        fmt_e              fmt;
        logic [POS_W-1:0]  pos;
        logic [OFF_W-1:0]  nxt_off;
        logic [OFF_W-1:0]  start;
        logic [REGS_W-1:0] regs;
        logic [IMM_W-1:0]  imm;
        logic              rv;
        logic [7:0]        r_op;
        fmt_e              r_fmt;
        logic [POS_W-1:0]  r_len;
        logic [REGS_W-1:0] r_regs;
        logic [IMM_W-1:0]  r_imm;
        logic [OFF_W-1:0]  r_off;
        logic              ev;
        err_e              e_code;
        logic [OFF_W-1:0]  e_off;
        logic [POS_W-1:0]  e_pos;
        logic [7:0]        e_val;
    } state_t;

    state_t state_d, state_q;

    fmt_e                 cls_fmt;
    logic                 cls_known;
    logic [MAX_REGS-1:0]  reg_we;
    logic [IMM_BYTES-1:0] imm_we;
    logic                 fm_last;
    logic                 op_byte;
    logic                 par_byte;
    logic [LANES-1:0]     lane_we;

    assign in_ready = 1'b1;
    assign op_byte  = in_valid && (in_sop || (state_q.st == ST_OPC));
    assign par_byte = in_valid && !in_sop && (state_q.st == ST_PARAM);
    assign lane_we  = {imm_we, reg_we};

    hbd_opclass u_opclass (
        .opcode (in_data),
        .fmt    (cls_fmt),
        .known  (cls_known)
    );

    hbd_fieldmap u_fieldmap (
        .en     (par_byte),
        .fmt    (state_q.fmt),
        .pos    (state_q.pos),
        .reg_we (reg_we),
        .imm_we (imm_we),
        .last   (fm_last)
    );

    always_comb begin
        logic [OFF_W-1:0]  op_off;
        logic [REGS_W-1:0] regs_n;
        logic [IMM_W-1:0]  imm_n;

        state_d    = state_q;
        state_d.rv = 1'b0;
        state_d.ev = 1'b0;
        op_off     = in_sop ? '0 : state_q.nxt_off;
        regs_n     = state_q.regs;
        imm_n      = state_q.imm;

        for (int k = 0; k < MAX_REGS; k++) begin
            if (reg_we[k]) regs_n[k*8 +: 8] = in_data;
        end
        for (int k = 0; k < IMM_BYTES; k++) begin
            if (imm_we[k]) imm_n[k*8 +: 8] = in_data;
        end

        if (op_byte) begin
            state_d.nxt_off = op_off + OFF_W'(1);
            if (!cls_known) begin
                state_d.ev     = 1'b1;
                state_d.e_code = ERR_OPCODE;
                state_d.e_off  = op_off;
                state_d.e_pos  = '0;
                state_d.e_val  = in_data;
                state_d.st     = ST_IDLE;
            end else if (cls_fmt == FMT_N) begin
                state_d.rv     = 1'b1;
                state_d.r_op   = in_data;
                state_d.r_fmt  = FMT_N;
                state_d.r_len  = fmt_len(FMT_N);
                state_d.r_regs = '0;
                state_d.r_imm  = '0;
                state_d.r_off  = op_off;
                state_d.st     = in_eop ? ST_IDLE : ST_OPC;
            end else if (in_eop) begin
                state_d.ev     = 1'b1;
                state_d.e_code = ERR_TRUNC;
                state_d.e_off  = op_off;
                state_d.e_pos  = POS_W'(1);
                state_d.e_val  = '0;
                state_d.st     = ST_IDLE;
            end else begin
                state_d.op    = in_data;
                state_d.fmt   = cls_fmt;
                state_d.pos   = POS_W'(1);
                state_d.start = op_off;
                state_d.regs  = '0;
                state_d.imm   = '0;
                state_d.st    = ST_PARAM;
            end
        end else if (par_byte) begin
            state_d.nxt_off = state_q.nxt_off + OFF_W'(1);
            if ((|reg_we) && (in_data >= REG_LIM_B)) begin
                state_d.ev     = 1'b1;
                state_d.e_code = ERR_REG;
                state_d.e_off  = state_q.start;
                state_d.e_pos  = state_q.pos;
                state_d.e_val  = in_data;
                state_d.st     = ST_IDLE;
            end else if (fm_last) begin
                state_d.rv     = 1'b1;
                state_d.r_op   = state_q.op;
                state_d.r_fmt  = state_q.fmt;
                state_d.r_len  = fmt_len(state_q.fmt);
                state_d.r_regs = regs_n;
                state_d.r_imm  = imm_n;
                state_d.r_off  = state_q.start;
                state_d.st     = in_eop ? ST_IDLE : ST_OPC;
            end else if (in_eop) begin
                state_d.ev     = 1'b1;
                state_d.e_code = ERR_TRUNC;
                state_d.e_off  = state_q.start;
                state_d.e_pos  = state_q.pos + POS_W'(1);
                state_d.e_val  = '0;
                state_d.st     = ST_IDLE;
            end else begin
                state_d.regs = regs_n;
                state_d.imm  = imm_n;
                state_d.pos  = state_q.pos + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rec_valid  = state_q.rv;
    assign rec_opcode = state_q.r_op;
    assign rec_fmt    = state_q.r_fmt;
    assign rec_len    = state_q.r_len;
    assign rec_regs   = state_q.r_regs;
    assign rec_imm    = state_q.r_imm;
    assign rec_offset = state_q.r_off;
    assign err_valid  = state_q.ev;
    assign err_code   = state_q.e_code;
    assign err_offset = state_q.e_off;
    assign err_pos    = state_q.e_pos;
    assign err_value  = state_q.e_val;

endmodule

// File: rtl/hbd_decoder_chk.sv
module hbd_decoder_chk
    import hbd_pkg::*;
#(
    parameter int REG_LIMIT = 60
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   rec_valid,
    input logic [POS_W-1:0]       rec_len,
    input logic [MAX_REGS*8-1:0]  rec_regs,
    input logic                   err_valid,
    input logic [1:0]             err_code,
    input logic [POS_W-1:0]       err_pos,
    input logic [7:0]             err_value,
    input logic [LANES-1:0]       lane_we
);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_valid && err_valid));

    a_r1_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_len inside {4'd1, 4'd3, 4'd4, 4'd5, 4'd10, 4'd11}));

    a_r2_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid || err_valid) |-> $past(in_valid));

    a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_we));

    for (genvar k = 0; k < MAX_REGS; k++) begin : g_reg_chk
        a_r3_reg_range: assert property (@(posedge clk) disable iff (!rst_n)
            rec_valid |-> (int'(rec_regs[k*8 +: 8]) < REG_LIMIT));
    end

    a_r5_opcode_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == 2'd1) |-> (err_pos == '0));

    a_r6_reg_value: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == 2'd2) |->
            ((int'(err_value) >= REG_LIMIT) && (err_pos != '0) && (err_pos <= POS_W'(MAX_REGS))));

    a_r7_trunc_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == 2'd3) |-> ((err_pos != '0) && (err_value == 8'd0)));

endmodule

bind hbd_decoder hbd_decoder_chk #(.REG_LIMIT(REG_LIMIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .rec_valid (rec_valid),
    .rec_len   (rec_len),
    .rec_regs  (rec_regs),
    .err_valid (err_valid),
    .err_code  (err_code),
    .err_pos   (err_pos),
    .err_value (err_value),
    .lane_we   (lane_we)
);

// File: tb/hbd_decoder_tb.sv
`timescale 1ns/1ps
module hbd_decoder_tb;

    localparam int OFF_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [7:0]        in_data = '0;
    logic              in_sop = 1'b0;
    logic              in_eop = 1'b0;
    logic              rec_valid;
    logic [7:0]        rec_opcode;
    logic [2:0]        rec_fmt;
    logic [3:0]        rec_len;
    logic [31:0]       rec_regs;
    logic [63:0]       rec_imm;
    logic [OFF_W-1:0]  rec_offset;
    logic              err_valid;
    logic [1:0]        err_code;
    logic [OFF_W-1:0]  err_offset;
    logic [3:0]        err_pos;
    logic [7:0]        err_value;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hbd_decoder #(.REG_LIMIT(60), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
        .rec_valid(rec_valid), .rec_opcode(rec_opcode), .rec_fmt(rec_fmt),
        .rec_len(rec_len), .rec_regs(rec_regs), .rec_imm(rec_imm),
        .rec_offset(rec_offset), .err_valid(err_valid), .err_code(err_code),
        .err_offset(err_offset), .err_pos(err_pos), .err_value(err_value)
    );

    typedef struct packed {
        logic [3:0]  n;
        logic [87:0] b;
        logic [2:0]  fmt;
        logic [31:0] regs;
        logic [63:0] imm;
    } tv_t;

    localparam tv_t TV [13] = '{
        '{4'd1,  88'h00, 3'd0, 32'h0, 64'h0},
        '{4'd4,  88'h03_02_01_01, 3'd2, 32'h00030201, 64'h0},
        '{4'd5,  88'h07_06_05_04_0C, 3'd3, 32'h07060504, 64'h0},
        '{4'd3,  88'h3B_09_0E, 3'd1, 32'h00003B09, 64'h0},
        '{4'd10, 88'h11_22_33_44_55_66_77_88_0A_1D, 3'd4, 32'h0000000A, 64'h1122334455667788},
        '{4'd11, 88'h01_02_03_04_05_06_07_08_02_01_27, 3'd5, 32'h00000201, 64'h0102030405060708},
        '{4'd1,  88'h2D, 3'd0, 32'h0, 64'h0},
        '{4'd11, 88'hFF_FF_FF_FF_FF_FF_FF_FF_00_3A_32, 3'd5, 32'h0000003A, 64'hFFFFFFFFFFFFFFFF},
        '{4'd5,  88'h00_00_00_00_30, 3'd3, 32'h0, 64'h0},
        '{4'd3,  88'h03_02_1C, 3'd1, 32'h00000302, 64'h0},
        '{4'd4,  88'h01_01_01_2F, 3'd2, 32'h00010101, 64'h0},
        '{4'd11, 88'h00_00_00_00_00_00_00_01_06_05_1B, 3'd5, 32'h00000605, 64'h1},
        '{4'd10, 88'h00_00_00_00_00_00_00_80_07_26, 3'd4, 32'h00000007, 64'h80}
    };

    task automatic chk(input string rq, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // drive one byte at a negedge; outputs for it are visible at the next negedge
    task automatic put(input logic [7:0] b, input logic sop, input logic eop);
        in_valid = 1'b1;
        in_data  = b;
        in_sop   = sop;
        in_eop   = eop;
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic chk_err(input string rq, input logic [1:0] code, input int off,
                           input int pos, input int val);
        chk(rq, "err_valid", 64'(err_valid), 64'd1);
        chk(rq, "rec_valid", 64'(rec_valid), 64'd0);
        chk(rq, "err_code", 64'(err_code), 64'(code));
        chk(rq, "err_offset", 64'(err_offset), 64'(off));
        chk(rq, "err_pos", 64'(err_pos), 64'(pos));
        chk(rq, "err_value", 64'(err_value), 64'(val));
    endtask

    task automatic chk_rec(input string rq, input logic [7:0] op, input int off, input int len);
        chk(rq, "rec_valid", 64'(rec_valid), 64'd1);
        chk(rq, "err_valid", 64'(err_valid), 64'd0);
        chk(rq, "rec_opcode", 64'(rec_opcode), 64'(op));
        chk(rq, "rec_offset", 64'(rec_offset), 64'(off));
        chk(rq, "rec_len", 64'(rec_len), 64'(len));
    endtask

    task automatic chk_quiet(input string rq);
        chk(rq, "rec_valid quiet", 64'(rec_valid), 64'd0);
        chk(rq, "err_valid quiet", 64'(err_valid), 64'd0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !done) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset", "rec_valid", 64'(rec_valid), 64'd0);
        chk("reset", "err_valid", 64'(err_valid), 64'd0);
        chk("reset", "in_ready", 64'(in_ready), 64'd1);

        // R1 R2 R3 R4: table of one-instruction programs
        for (int i = 0; i < 13; i++) begin
            for (int j = 0; j < int'(TV[i].n); j++) begin
                put(TV[i].b[j*8 +: 8], j == 0, j == int'(TV[i].n) - 1);
            end
            chk_rec("R1", TV[i].b[7:0], 0, int'(TV[i].n));
            chk("R1", "rec_fmt", 64'(rec_fmt), 64'(TV[i].fmt));
            chk("R3", "rec_regs", 64'(rec_regs), 64'(TV[i].regs));
            chk("R4", "rec_imm", rec_imm, TV[i].imm);
            @(negedge clk);
            chk_quiet("R2");
        end

        // R2: offsets within one program
        put(8'h00, 1, 0);
        chk_rec("R2", 8'h00, 0, 1);
        put(8'h01, 0, 0); chk_quiet("R2");
        put(8'h01, 0, 0); put(8'h02, 0, 0);
        put(8'h03, 0, 0);
        chk_rec("R2", 8'h01, 1, 4);
        put(8'h0E, 0, 0); put(8'h09, 0, 0); put(8'h3B, 0, 1);
        chk_rec("R2", 8'h0E, 5, 3);

        // R5: undefined opcodes
        foreach (TV[i]) begin end
        for (int i = 0; i < 5; i++) begin
            logic [7:0] bad;
            bad = (i == 0) ? 8'd15 : (i == 1) ? 8'd16 : (i == 2) ? 8'd17 : (i == 3) ? 8'd51 : 8'd255;
            put(bad, 1, 0);
            chk_err("R5", 2'd1, 0, 0, int'(bad));
        end
        put(8'h00, 1, 0); put(8'h10, 0, 0);
        chk_err("R5", 2'd1, 1, 0, 16);

        // R6: register range
        put(8'h01, 1, 0); put(8'h01, 0, 0); put(8'h3C, 0, 0);
        chk_err("R6", 2'd2, 0, 2, 60);
        put(8'h27, 1, 0); put(8'hC8, 0, 0);
        chk_err("R6", 2'd2, 0, 1, 200);

        // R8: ignored after error until start flag
        put(8'h00, 0, 0); chk_quiet("R8");
        put(8'h00, 0, 1); chk_quiet("R8");
        put(8'h00, 1, 1);
        chk_rec("R8", 8'h00, 0, 1);

        // R7: truncation
        put(8'h1D, 1, 0); put(8'h05, 0, 0); put(8'h11, 0, 0); put(8'h22, 0, 1);
        chk_err("R7", 2'd3, 0, 4, 0);
        put(8'h01, 1, 1);
        chk_err("R7", 2'd3, 0, 1, 0);
        put(8'h00, 1, 0); put(8'h01, 0, 0); put(8'h02, 0, 1);
        chk_err("R7", 2'd3, 1, 2, 0);

        // R11: bad register on the end byte reports code 2
        put(8'h01, 1, 0); put(8'h01, 0, 0); put(8'h3D, 0, 1);
        chk_err("R11", 2'd2, 0, 2, 61);

        // R9: start flag mid-instruction restarts
        put(8'h1D, 1, 0); put(8'h01, 0, 0); put(8'h00, 1, 0);
        chk_rec("R9", 8'h00, 0, 1);
        put(8'h0E, 0, 0); put(8'h01, 0, 0); put(8'h02, 0, 1);
        chk_rec("R9", 8'h0E, 1, 3);
        chk("R9", "rec_regs", 64'(rec_regs), 64'h0201);

        // R10: clean end, trailing bytes ignored
        put(8'h2D, 1, 1);
        chk_rec("R10", 8'h2D, 0, 1);
        put(8'h00, 0, 0); chk_quiet("R10");
        put(8'h01, 0, 0); chk_quiet("R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule